// File: doc/BRIEF.md
# Dual-Mode Interrupt Priority Controller

This block chooses which pending interrupt, if any, is presented to the processor. It takes a bank of maskable request lines, each gated by its own enable bit, and a single non-maskable request. A 2-bit control-mode register selects one of two masking schemes. In flat mode, one processor mask bit blocks every maskable source at once. In level mode, each source carries a programmable 3-bit priority, and that priority is compared against the processor's 3-bit mask level.

Every cycle the block reports three things: whether a request is pending for the processor, the vector number of the winning source, and its priority level. The non-maskable request outranks every other request. It is blocked only while the block is in reset or in standby. The two reserved mode encodings are refused: a write of either one leaves the working mode as it was and raises a sticky error flag. Vector fetch, context saving and the update of the processor mask when an interrupt is accepted belong to the processor and are not part of this block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While `rst` is high on a clock edge, `int_req`, `int_vec` and `int_lvl` become 0, `cur_mode` becomes 00 and `mode_err` becomes 0.
- R2: When `nmi_req` is high and `standby` is low, the next cycle shows `int_req`=1, `int_vec`=NUM_SRC and `int_lvl`=8. This holds whatever the enables, the mask bit, the mask level and the maskable requests are.
- R3: While `standby` is high, no request is reported in the next cycle: `int_req`, `int_vec` and `int_lvl` are all 0, even when `nmi_req` is high.
- R4: A source whose `irq_en` bit is 0 never wins, in either mode.
- R5: In mode 00, `cpu_i`=1 blocks every maskable source. With `cpu_i`=0, the lowest-numbered enabled pending source wins and is reported with `int_lvl`=0. The value of `cpu_mask_lvl` has no effect in this mode.
- R6: In mode 10, source i takes its priority from `prio_cfg[3*i+2:3*i]`. It is eligible only when that priority is strictly greater than `cpu_mask_lvl`, and `int_lvl` reports that priority. The value of `cpu_i` has no effect in this mode.
- R7: In mode 10, a source with priority 7 is eligible even when `cpu_mask_lvl` is 7.
- R8: In mode 10, the eligible source with the highest priority wins. When several eligible sources share that priority, the lowest-numbered one wins.
- R9: A write (`mode_wr`=1) of 00 or 10 loads `cur_mode` on the next edge. A write of 01 or 11 leaves `cur_mode` unchanged and sets `mode_err`, which stays 1 until reset.
- R10: The outputs are registered: they reflect the inputs and the working mode of the previous cycle. `int_req` stays high on every cycle for as long as an eligible source stays pending. When no request is reported, `int_vec` and `int_lvl` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Standby state; blocks all requests |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Mode value to write |
| nmi_req | input | 1 | Non-maskable request |
| irq_req | input | NUM_SRC | Maskable request lines |
| irq_en | input | NUM_SRC | Per-source enable bits |
| prio_cfg | input | 3*NUM_SRC | Per-source 3-bit priorities |
| cpu_i | input | 1 | Processor global mask bit (mode 00) |
| cpu_mask_lvl | input | 3 | Processor mask level (mode 10) |
| int_req | output | 1 | Request to the processor |
| int_vec | output | clog2(NUM_SRC+1) | Winning vector number (NUM_SRC for the non-maskable request) |
| int_lvl | output | 4 | Winning priority (8 for the non-maskable request) |
| cur_mode | output | 2 | Mode currently in force |
| mode_err | output | 1 | Sticky flag for a write of a reserved mode |

## Verification
The assertions run on every cycle. They check that the non-maskable request always wins, that standby silences the outputs, and that the working mode never holds a reserved encoding. They also check that a reserved write keeps the mode unchanged and leaves the error flag latched, that a reported maskable winner was both enabled and pending, and that in level mode the reported level clears the mask or is 7. Which source wins among several eligible ones can only be shown by the bench's scenarios, as can the tie order, the lowest-index choice in flat mode and the inputs that have no effect in each mode. The bench compares these against its reference model on every clock.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    typedef enum logic [1:0] {
        MODE_FLAT  = 2'b00,
        MODE_RSV1  = 2'b01,
        MODE_LEVEL = 2'b10,
        MODE_RSV3  = 2'b11
    } ctl_mode_e;

    localparam int PRIO_W  = 3;
    localparam int LVL_W   = 4;
    localparam logic [LVL_W-1:0]  NMI_LVL = 4'd8;
    localparam logic [PRIO_W-1:0] TOP_PRIO = 3'd7;

    typedef struct packed {
        logic             hit;
        logic [LVL_W-1:0] lvl;
    } cand_t;

    function automatic logic mode_ok(input logic [1:0] m);
        return (m == MODE_FLAT) || (m == MODE_LEVEL);
    endfunction

    function automatic logic clears_mask(input logic [PRIO_W-1:0] p,
                                         input logic [PRIO_W-1:0] m);
        return (p == TOP_PRIO) || (p > m);
    endfunction

endpackage

// File: rtl/ipc_mode_reg.sv
module ipc_mode_reg
    import ipc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  logic [1:0] wdata,
    output ctl_mode_e mode,
    output logic      err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_FLAT;
            err  <= 1'b0;
        end else if (wr) begin
            if (mode_ok(wdata)) begin
                mode <= ctl_mode_e'(wdata);
            end else begin
                err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ipc_src_qual.sv
module ipc_src_qual
    import ipc_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  ctl_mode_e                  mode,
    input  logic                       cpu_i,
    input  logic [PRIO_W-1:0]          mask_lvl,
    input  logic [NUM_SRC-1:0]         req,
    input  logic [NUM_SRC-1:0]         en,
    input  logic [NUM_SRC*PRIO_W-1:0]  prio,
    output cand_t [NUM_SRC-1:0]        cand
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic [PRIO_W-1:0] p;
        logic              live;
        assign p    = prio[i*PRIO_W +: PRIO_W];
        assign live = req[i] & en[i];

        always_comb begin
            cand[i].hit = 1'b0;
            cand[i].lvl = '0;
            unique case (mode)
                MODE_FLAT: begin
                    cand[i].hit = live & ~cpu_i;
                end
                MODE_LEVEL: begin
                    cand[i].hit = live & clears_mask(p, mask_lvl);
                    cand[i].lvl = {1'b0, p};
                end
                default: begin
                    cand[i].hit = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/ipc_pick.sv
module ipc_pick
    import ipc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 4
) (
    input  cand_t [NUM_SRC-1:0] cand,
    output logic                found,
    output logic [VEC_W-1:0]    vec,
    output logic [LVL_W-1:0]    lvl
);

    // Scan from the highest index down; ">=" lets a lower index take a tie.
    always_comb begin
        found = 1'b0;
        vec   = '0;
        lvl   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (cand[i].hit && (!found || cand[i].lvl >= lvl)) begin
                found = 1'b1;
                vec   = VEC_W'(i);
                lvl   = cand[i].lvl;
            end
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import ipc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int VEC_W  = $clog2(NUM_SRC + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      standby,
    input  logic                      mode_wr,
    input  logic [1:0]                mode_wdata,
    input  logic                      nmi_req,
    input  logic [NUM_SRC-1:0]        irq_req,
    input  logic [NUM_SRC-1:0]        irq_en,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_cfg,
    input  logic                      cpu_i,
    input  logic [PRIO_W-1:0]         cpu_mask_lvl,
    output logic                      int_req,
    output logic [VEC_W-1:0]          int_vec,
    output logic [LVL_W-1:0]          int_lvl,
    output logic [1:0]                cur_mode,
    output logic                      mode_err
);

    localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(NUM_SRC);

    ctl_mode_e            mode_q;
    cand_t [NUM_SRC-1:0]  cand;
    logic                 pick_found;
    logic [VEC_W-1:0]     pick_vec;
    logic [LVL_W-1:0]     pick_lvl;
    logic                 nx_req;
    logic [VEC_W-1:0]     nx_vec;
    logic [LVL_W-1:0]     nx_lvl;

    ipc_mode_reg u_mode (
        .clk   (clk),
        .rst   (rst),
        .wr    (mode_wr),
        .wdata (mode_wdata),
        .mode  (mode_q),
        .err   (mode_err)
    );

    ipc_src_qual #(.NUM_SRC(NUM_SRC)) u_qual (
        .mode     (mode_q),
        .cpu_i    (cpu_i),
        .mask_lvl (cpu_mask_lvl),
        .req      (irq_req),
        .en       (irq_en),
        .prio     (prio_cfg),
        .cand     (cand)
    );

    ipc_pick #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_pick (
        .cand  (cand),
        .found (pick_found),
        .vec   (pick_vec),
        .lvl   (pick_lvl)
    );

    always_comb begin
        nx_req = 1'b0;
        nx_vec = '0;
        nx_lvl = '0;
        if (!standby) begin
            if (nmi_req) begin
                nx_req = 1'b1;
                nx_vec = NMI_VEC;
                nx_lvl = NMI_LVL;
            end else if (pick_found) begin
                nx_req = 1'b1;
                nx_vec = pick_vec;
                nx_lvl = pick_lvl;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            int_req <= 1'b0;
            int_vec <= '0;
            int_lvl <= '0;
        end else begin
            int_req <= nx_req;
            int_vec <= nx_vec;
            int_lvl <= nx_lvl;
        end
    end

    assign cur_mode = mode_q;

endmodule

// File: rtl/ipc_checker.sv
module ipc_checker
    import ipc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      standby,
    input logic                      mode_wr,
    input logic [1:0]                mode_wdata,
    input logic                      nmi_req,
    input logic [NUM_SRC-1:0]        irq_req,
    input logic [NUM_SRC-1:0]        irq_en,
    input logic [PRIO_W-1:0]         cpu_mask_lvl,
    input logic                      int_req,
    input logic [VEC_W-1:0]          int_vec,
    input logic [LVL_W-1:0]          int_lvl,
    input logic [1:0]                cur_mode,
    input logic                      mode_err
);

    // R2
    nmi_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (nmi_req && !standby) |=> (int_req && int_vec == VEC_W'(NUM_SRC) && int_lvl == NMI_LVL));

    // R3
    standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        standby |=> (!int_req && int_vec == '0 && int_lvl == '0));

    // R9
    mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        cur_mode[0] == 1'b0);

    // R9
    bad_write_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && mode_wdata[0]) |=> ($stable(cur_mode) && mode_err));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        mode_err |=> mode_err);

    // R4
    winner_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        (int_req && int_lvl != NMI_LVL) |->
            ((($past(irq_en & irq_req) >> int_vec) & NUM_SRC'(1)) != '0));

    // R6 R7
    level_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (int_req && int_lvl != NMI_LVL && $past(cur_mode) == 2'b10) |->
            (int_lvl[PRIO_W-1:0] == TOP_PRIO || int_lvl[PRIO_W-1:0] > $past(cpu_mask_lvl)));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !int_req |-> (int_vec == '0 && int_lvl == '0));

endmodule

bind irq_prio_ctrl ipc_checker #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .standby      (standby),
    .mode_wr      (mode_wr),
    .mode_wdata   (mode_wdata),
    .nmi_req      (nmi_req),
    .irq_req      (irq_req),
    .irq_en       (irq_en),
    .cpu_mask_lvl (cpu_mask_lvl),
    .int_req      (int_req),
    .int_vec      (int_vec),
    .int_lvl      (int_lvl),
    .cur_mode     (cur_mode),
    .mode_err     (mode_err)
);

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;

    localparam int N  = 8;
    localparam int VW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          standby = 1'b0;
    logic          mode_wr = 1'b0;
    logic [1:0]    mode_wdata = 2'b00;
    logic          nmi_req = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic [N-1:0]  irq_en = '0;
    logic [3*N-1:0] prio_cfg = '0;
    logic          cpu_i = 1'b0;
    logic [2:0]    cpu_mask_lvl = 3'd0;
    logic          int_req;
    logic [VW-1:0] int_vec;
    logic [3:0]    int_lvl;
    logic [1:0]    cur_mode;
    logic          mode_err;

    irq_prio_ctrl #(.NUM_SRC(N)) uut (
        .clk(clk), .rst(rst), .standby(standby), .mode_wr(mode_wr),
        .mode_wdata(mode_wdata), .nmi_req(nmi_req), .irq_req(irq_req),
        .irq_en(irq_en), .prio_cfg(prio_cfg), .cpu_i(cpu_i),
        .cpu_mask_lvl(cpu_mask_lvl), .int_req(int_req), .int_vec(int_vec),
        .int_lvl(int_lvl), .cur_mode(cur_mode), .mode_err(mode_err)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int m_mode = 0;
    int m_err  = 0;

    task automatic tick(input string tag);
        int e_req, e_vec, e_lvl, best, best_lvl, p;
        e_req = 0; e_vec = 0; e_lvl = 0;
        if (rst) begin
            m_mode = 0;
            m_err  = 0;
        end else begin
            if (!standby) begin
                if (nmi_req) begin
                    e_req = 1; e_vec = N; e_lvl = 8;
                end else begin
                    best = -1; best_lvl = -1;
                    for (int i = 0; i < N; i++) begin
                        p = int'(prio_cfg[3*i +: 3]);
                        if (irq_req[i] && irq_en[i]) begin
                            if (m_mode == 0 && !cpu_i && best < 0) begin
                                best = i; best_lvl = 0;
                            end else if (m_mode == 2 && (p == 7 || p > int'(cpu_mask_lvl))
                                         && p > best_lvl) begin
                                best = i; best_lvl = p;
                            end
                        end
                    end
                    if (best >= 0) begin
                        e_req = 1; e_vec = best; e_lvl = best_lvl;
                    end
                end
            end
            if (mode_wr) begin
                if (mode_wdata == 2'b00 || mode_wdata == 2'b10) m_mode = int'(mode_wdata);
                else m_err = 1;
            end
        end
        @(posedge clk);
        #1;
        checks++;
        if (int'(int_req) != e_req || int'(int_vec) != e_vec || int'(int_lvl) != e_lvl ||
            int'(cur_mode) != m_mode || int'(mode_err) != m_err) begin
            errors++;
            $display("FAIL %s: req/vec/lvl/mode/err actual=%0d/%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d/%0d",
                     tag, int_req, int_vec, int_lvl, cur_mode, mode_err,
                     e_req, e_vec, e_lvl, m_mode, m_err);
        end
    endtask

    task automatic set_prio(input int src, input int lvl);
        prio_cfg[3*src +: 3] = 3'(lvl);
    endtask

    task automatic write_mode(input logic [1:0] v, input string tag);
        mode_wr = 1'b1; mode_wdata = v;
        tick(tag);
        mode_wr = 1'b0;
    endtask

    initial begin
        #1;
        irq_req = '1; irq_en = '1; nmi_req = 1'b1;
        tick("R1 reset");
        tick("R1 reset");
        rst = 1'b0; irq_req = '0; irq_en = '0; nmi_req = 1'b0;
        tick("R1 idle after reset");

        // Flat mode
        irq_req = 8'b0010_1000; irq_en = 8'hFF; cpu_mask_lvl = 3'd7;
        tick("R10 latency");
        tick("R5 lowest index, mask level ignored");
        tick("R10 held");
        cpu_i = 1'b1;
        tick("R5 global mask");
        tick("R5 global mask");
        cpu_i = 1'b0; irq_en = 8'b1111_0111;
        tick("R4 disabled source skipped");
        tick("R4 disabled source skipped");
        irq_en = '0;
        tick("R4 all disabled");
        tick("R4 all disabled");

        // NMI and standby
        nmi_req = 1'b1; cpu_i = 1'b1; irq_en = '1;
        tick("R2 nmi");
        tick("R2 nmi");
        standby = 1'b1;
        tick("R3 standby");
        tick("R3 standby");
        standby = 1'b0; nmi_req = 1'b0; cpu_i = 1'b0;
        tick("R2 release");

        // Reserved writes
        write_mode(2'b01, "R9 reserved 01");
        tick("R9 reserved 01");
        write_mode(2'b11, "R9 reserved 11");
        tick("R9 sticky");
        write_mode(2'b10, "R9 valid 10");
        tick("R9 valid 10");
        write_mode(2'b11, "R9 reserved keeps level");
        tick("R9 reserved keeps level");

        // Level mode
        irq_req = '0; irq_en = '1; cpu_i = 1'b1;
        for (int i = 0; i < N; i++) set_prio(i, i % 8);
        irq_req = 8'b0001_0110; cpu_mask_lvl = 3'd1;
        tick("R6 cpu_i ignored");
        tick("R6 priority above mask");
        cpu_mask_lvl = 3'd4;
        tick("R6 all at or below mask");
        tick("R6 all at or below mask");
        irq_req = 8'b1000_0001; cpu_mask_lvl = 3'd7;
        tick("R7 level 7 at mask 7");
        tick("R7 level 7 at mask 7");
        set_prio(2, 5); set_prio(5, 5); set_prio(6, 5);
        irq_req = 8'b0110_0100; cpu_mask_lvl = 3'd0;
        tick("R8 tie lowest index");
        tick("R8 tie lowest index");
        set_prio(6, 6);
        tick("R8 highest priority");
        tick("R8 highest priority");
        irq_en = 8'b1011_1111;
        tick("R4 level disabled");
        tick("R4 level disabled");

        // Back to flat, then randomized stress
        write_mode(2'b00, "R9 valid 00");
        tick("R5 back in flat");
        for (int k = 0; k < 400; k++) begin
            irq_req      = N'($urandom);
            irq_en       = N'($urandom);
            prio_cfg     = (3*N)'($urandom);
            cpu_i        = ($urandom % 4) == 0;
            cpu_mask_lvl = 3'($urandom);
            nmi_req      = ($urandom % 16) == 0;
            standby      = ($urandom % 20) == 0;
            mode_wr      = ($urandom % 10) == 0;
            mode_wdata   = 2'($urandom);
            tick("R8 random");
        end
        mode_wr = 1'b0; standby = 1'b0; nmi_req = 1'b0;
        rst = 1'b1;
        tick("R1 late reset");
        rst = 1'b0;
        tick("R1 after late reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule